// File: doc/BRIEF.md
# Descrambler Seed Watchdog

This block watches the seed-update events produced by a 100 Mb/s descrambler. While the descrambler is enabled, a counter measures the time since the last seed update. If that time reaches a programmable limit, the block raises a no-seed alarm. The limit defaults to 40000 cycles, which is 1.6 ms at a 25 MHz clock and falls inside the required 1.3 to 2 ms window.

The alarm is sticky. It stays high after the timeout condition has gone away, and only a status-read strobe clears it. A read that arrives while the timeout is still live leaves the alarm set, so software cannot lose an ongoing fault.

The descrambler itself is not part of this block. It only has to supply an enable level and a one-cycle pulse on each seed update.

Top module: `seed_watchdog`

## Requirements
- R1: A rising edge with `rst_n` low clears `no_seed` to 0 and restarts the timeout window. `no_seed` reads 0 after reset.
- R2: A "quiet edge" is a rising edge with `rst_n`=1, `desc_en`=1 and `seed_upd`=0. `no_seed` goes to 1 at the edge that is the (TIMEOUT_CYCLES+1)th consecutive quiet edge. It is still 0 after TIMEOUT_CYCLES consecutive quiet edges.
- R3: An edge with `seed_upd`=1 restarts the count of consecutive quiet edges. When updates arrive at least every TIMEOUT_CYCLES+1 edges, `no_seed` never rises.
- R4: An edge with `desc_en`=0 never sets `no_seed` and restarts the count. After re-enabling, a full window of TIMEOUT_CYCLES+1 quiet edges is needed again.
- R5: Once set, `no_seed` stays 1 through seed updates and through the descrambler being disabled, as long as `stat_rd` is 0.
- R6: An edge with `stat_rd`=1 clears `no_seed` when that edge does not itself set the alarm under R2.
- R7: An edge with `stat_rd`=1 that is also a setting edge under R2 leaves `no_seed` at 1.
- R8: `stat_rd` pulses while `no_seed` is 0 have no effect. They neither set the flag nor disturb the timeout window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_en | input | 1 | Descrambler enable level; the watchdog is armed while it is 1 |
| seed_upd | input | 1 | One-cycle pulse on each seed update |
| stat_rd | input | 1 | Status-read strobe; clears the latched alarm |
| no_seed | output | 1 | Sticky no-seed alarm |

## Verification
Every result here is registered, so an input pattern applied before a rising edge shows on `no_seed` right after that edge. The alarm itself rises on exactly the (TIMEOUT_CYCLES+1)th consecutive quiet edge.

The bench drives inputs at the falling edge and applies each pattern for a counted number of rising edges. It then samples `no_seed` at the following falling edge. This places each check on both sides of the exact edge at which the flag is due to change: one quiet edge short of the limit, and on the limit itself.

// File: rtl/seed_wd_pkg.sv
// Package: shared constants and helpers for the seed watchdog.
// Assumes a clock of 25 MHz for the default timeout figure.
package seed_wd_pkg;
    // Default timeout: 1.6 ms at 25 MHz.
    localparam int unsigned DEFAULT_TIMEOUT = 40000;

    // Width needed to hold the values 0 .. limit.
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction
endpackage

// File: rtl/seed_wd_timer.sv
// Module: seed_wd_timer
// Counts consecutive quiet cycles (enabled, no seed update) and saturates
// at the limit. Drives 'live' when the current edge would be a
// timeout edge. Assumes TIMEOUT_CYCLES >= 1 and a one-cycle seed pulse.
module seed_wd_timer
    import seed_wd_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = DEFAULT_TIMEOUT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic desc_en,
    input  logic seed_upd,
    output logic live
);
    localparam int unsigned CNT_W = cnt_width(TIMEOUT_CYCLES);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES);

    logic [CNT_W-1:0] quiet_cnt;
    logic             at_limit;

    // Count quiet cycles; restart on reset, disable or seed update; saturate.
    always_ff @(posedge clk) begin
        if (!rst_n || !desc_en || seed_upd) begin
            quiet_cnt <= '0;
        end else if (!at_limit) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    // Timeout is live only on an edge that is itself quiet.
    always_comb begin
        at_limit = (quiet_cnt == LIMIT);
        live     = at_limit && desc_en && !seed_upd;
    end

    // Counter never passes the limit.
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_cnt <= LIMIT);

    // A seed update leaves no live timeout on the following edge.
    assert_update_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seed_upd |=> !live);
endmodule

// File: rtl/seed_wd_alarm.sv
// Module: seed_wd_alarm
// Sticky alarm latch: set by a live timeout, cleared by a status read
// only when no timeout is live on that edge (set wins).
module seed_wd_alarm (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic stat_rd,
    output logic flag
);
    // Latch the alarm; setting has priority over the read-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (live) begin
            flag <= 1'b1;
        end else if (stat_rd) begin
            flag <= 1'b0;
        end
    end

    // Held high until a read.
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !stat_rd |=> flag);

    // A read with no live timeout clears the flag.
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !live |=> !flag);

    // A live timeout always leaves the flag set.
    assert_read_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        live |=> flag);
endmodule

// File: rtl/seed_watchdog.sv
// Module: seed_watchdog (top)
// Raises a sticky no-seed alarm when the descrambler stays enabled for
// more than TIMEOUT_CYCLES cycles without a seed update. Assumes all
// inputs are synchronous to clk.
module seed_watchdog
    import seed_wd_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = DEFAULT_TIMEOUT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic desc_en,
    input  logic seed_upd,
    input  logic stat_rd,
    output logic no_seed
);
    logic timeout_live;

    seed_wd_timer #(
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .desc_en (desc_en),
        .seed_upd(seed_upd),
        .live    (timeout_live)
    );

    seed_wd_alarm u_alarm (
        .clk    (clk),
        .rst_n  (rst_n),
        .live   (timeout_live),
        .stat_rd(stat_rd),
        .flag   (no_seed)
    );

    // Alarm can only rise from an edge where the descrambler was enabled.
    assert_only_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(no_seed) |-> $past(desc_en));

    // Reset always leaves the alarm low.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> !no_seed);
endmodule

// File: tb/seed_watchdog_tb.sv
// Bench for seed_watchdog: a segment table walked by one loop, then
// directed tests for reset and update spacing.
module seed_watchdog_tb;
    localparam int unsigned T = 8;

    typedef struct packed {
        logic       en;
        logic       upd;
        logic       rd;
        logic [7:0] n;    // rising edges the pattern is held
        logic       exp;  // expected no_seed after those edges
        logic [3:0] req;
    } seg_t;

    localparam int NSEG = 17;
    localparam seg_t SEGS [NSEG] = '{
        '{1'b1, 1'b0, 1'b0, 8'd8,  1'b0, 4'd2}, // R2 one short of limit
        '{1'b1, 1'b0, 1'b0, 8'd1,  1'b1, 4'd2}, // R2 rises on edge T+1
        '{1'b1, 1'b0, 1'b1, 8'd1,  1'b1, 4'd7}, // R7 read while live
        '{1'b1, 1'b1, 1'b0, 8'd1,  1'b1, 4'd5}, // R5 update keeps flag
        '{1'b1, 1'b0, 1'b1, 8'd1,  1'b0, 4'd6}, // R6 read clears
        '{1'b1, 1'b0, 1'b0, 8'd6,  1'b0, 4'd3}, // R3 count at 7
        '{1'b1, 1'b1, 1'b0, 8'd1,  1'b0, 4'd3}, // R3 update restarts
        '{1'b1, 1'b0, 1'b0, 8'd8,  1'b0, 4'd3}, // R3 full window again
        '{1'b0, 1'b0, 1'b0, 8'd1,  1'b0, 4'd4}, // R4 disabled edge never sets
        '{1'b0, 1'b0, 1'b0, 8'd30, 1'b0, 4'd4}, // R4 long disable
        '{1'b1, 1'b0, 1'b0, 8'd8,  1'b0, 4'd4}, // R4 window restarted
        '{1'b1, 1'b0, 1'b0, 8'd1,  1'b1, 4'd4}, // R4 rises after full window
        '{1'b0, 1'b0, 1'b0, 8'd5,  1'b1, 4'd5}, // R5 held while disabled
        '{1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 4'd6}, // R6 read clears
        '{1'b0, 1'b0, 1'b1, 8'd3,  1'b0, 4'd8}, // R8 reads while low
        '{1'b1, 1'b0, 1'b1, 8'd8,  1'b0, 4'd8}, // R8 reads do not disturb window
        '{1'b1, 1'b0, 1'b1, 8'd1,  1'b1, 4'd7}  // R7 read on setting edge
    };

    logic clk = 1'b0;
    logic rst_n, desc_en, seed_upd, stat_rd;
    logic no_seed;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #2 clk = ~clk;

    seed_watchdog #(.TIMEOUT_CYCLES(T)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .desc_en (desc_en),
        .seed_upd(seed_upd),
        .stat_rd (stat_rd),
        .no_seed (no_seed)
    );

    task automatic check(input logic exp, input int req, input int step);
        n_chk++;
        if (no_seed !== exp) begin
            n_bad++;
            $display("FAIL R%0d step %0d: no_seed=%b expected %b", req, step, no_seed, exp);
        end
    endtask

    // Hold a pattern for n rising edges, then sample at the falling edge.
    task automatic run(input logic en, input logic upd, input logic rd, input int n);
        desc_en  = en;
        seed_upd = upd;
        stat_rd  = rd;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; desc_en = 1'b1; seed_upd = 1'b0; stat_rd = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1'b0, 1, 0);                 // R1 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NSEG; i++) begin
            run(SEGS[i].en, SEGS[i].upd, SEGS[i].rd, int'(SEGS[i].n));
            check(SEGS[i].exp, int'(SEGS[i].req), i + 1);
        end

        // R1: reset clears a set flag and restarts the window.
        rst_n = 1'b0;
        run(1'b1, 1'b0, 1'b0, 1);
        check(1'b0, 1, 100);
        rst_n = 1'b1;
        run(1'b1, 1'b0, 1'b0, T);
        check(1'b0, 1, 101);
        run(1'b1, 1'b0, 1'b0, 1);
        check(1'b1, 1, 102);
        run(1'b0, 1'b0, 1'b1, 1);
        check(1'b0, 6, 103);

        // R3: updates every T+1 edges never raise the alarm.
        for (int k = 0; k < 5; k++) begin
            run(1'b1, 1'b0, 1'b0, T);
            run(1'b1, 1'b1, 1'b0, 1);
            check(1'b0, 3, 200 + k);
        end
        // R2: spacing of T+2 edges does raise it.
        run(1'b1, 1'b0, 1'b0, T + 1);
        check(1'b1, 2, 300);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R0 watchdog: done=%b expected %b", done, 1'b1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule